// File: doc/BRIEF.md
# Disk Arm Request Scheduler

This block keeps a short list of pending cylinder requests for a disk head and decides which one is serviced next. Requests arrive on a valid/ready push port. The chosen cylinder leaves on a valid/ready grant port. The choice follows one of five policies picked at run time: arrival order, nearest cylinder, a full back-and-forth sweep, an upward-only sweep that returns through the disk edge, and an upward-only sweep that wraps straight to the lowest pending request.

The block holds the present head cylinder and the sweep direction. Both are loaded from inputs while reset is held. When a grant is accepted, the head moves to the granted cylinder and the cylinders crossed on the way are added to a running movement total. Seek cost is counted as the number of cylinders crossed. When a sweep passes a disk edge, the travel to that edge is counted as well.

A grant offer is formed one cycle after a cycle with no push and no accept, so it always reflects the complete queue at that moment. Once offered, it stays in place until it is taken.

Top module: `disk_arm_scheduler`

## Requirements
- R1: Cylinders run from 0 to 199. A request or an initial head value above 199 is held as 199, so neither a grant nor the head ever exceeds 199.
- R2: Policy code 0 grants requests in arrival order. From head 53 with requests 98, 183, 37, 122, 14, 124, 65, 67 pushed in that order, the movement total ends at 640.
- R3: Policy code 1 grants the pending request nearest the head. For the R2 example, the order is 65, 67, 37, 14, 98, 122, 124, 183 and the total is 236.
- R4: Policy code 2 grants the nearest request at or beyond the head in the current direction. When none is left in that direction, the head travels to the disk edge (0 or 199), reverses, and the edge travel is counted. For the R2 example, starting downward gives 236 and starting upward gives 331.
- R5: Policy code 3 grants only upward. When nothing is at or above the head, the cost is the distance to 199, plus 199 for the return to 0, plus the target cylinder. For the R2 example, the total is 382.
- R6: Policy code 4 grants only upward. When nothing is at or above the head, it wraps directly to the lowest pending request at a cost equal to that difference. For the R2 example, the total is 322. Both circular policies leave the direction output high after a grant.
- R7: On each accepted grant, head_cyl becomes the granted cylinder and total_move grows by that grant's cost. Neither output changes without an accepted grant.
- R8: The queue holds 8 requests. req_ready is low while 8 are pending, and a push offered then is dropped. gnt_valid is low while the queue is empty.
- R9: Under policy code 1, when two pending requests are equally far from the head, the lower cylinder is granted first.
- R10: The policy input is sampled only while the queue is empty. A change while requests are pending has no effect until the queue drains.
- R11: While gnt_valid is high and gnt_ready is low, gnt_valid and gnt_cyl hold steady. A later, closer arrival does not displace the current offer.
- R12: During reset, the head loads from init_head, the direction loads from init_dir_up, total_move clears and gnt_valid is low. Policy codes 5 to 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_head | input | CYL_W | Head cylinder loaded while reset is high |
| init_dir_up | input | 1 | Starting sweep direction, 1 = toward higher cylinders |
| policy | input | 3 | Policy code (0 to 4, others as 0) |
| req_valid | input | 1 | Request offered |
| req_cyl | input | CYL_W | Requested cylinder |
| req_ready | output | 1 | Queue can accept a request |
| gnt_valid | output | 1 | A grant is offered |
| gnt_cyl | output | CYL_W | Granted cylinder |
| gnt_ready | input | 1 | Consumer takes the grant |
| head_cyl | output | CYL_W | Current head cylinder |
| dir_up | output | 1 | Current sweep direction |
| total_move | output | TOT_W | Accumulated cylinders crossed |

## Verification
A corrupted queue entry or a bad compaction after a removal shows up on the next offered gnt_cyl, two cycles after the accept that caused it: a grant is skipped, duplicated or out of order. A wrong head or direction register changes the ranking of every later choice and the cost of the very next grant. It therefore appears in total_move on the accept edge and in the grant order shortly after. Each policy is run over the same eight-request list, and the full grant order and the final total are compared, so any single misplaced pick or cost term shows in the total.

// File: rtl/disk_sched_pkg.sv
package disk_sched_pkg;

  typedef enum logic [2:0] {
    POL_FIFO    = 3'd0,
    POL_NEAREST = 3'd1,
    POL_SWEEP   = 3'd2,
    POL_CSWEEP  = 3'd3,
    POL_CLOOK   = 3'd4
  } sched_pol_e;

  function automatic sched_pol_e pol_decode(input logic [2:0] code);
    case (code)
      3'd1:    return POL_NEAREST;
      3'd2:    return POL_SWEEP;
      3'd3:    return POL_CSWEEP;
      3'd4:    return POL_CLOOK;
      default: return POL_FIFO;
    endcase
  endfunction

endpackage

// File: rtl/req_queue.sv
// Arrival-ordered request store. Slot 0 is always the oldest entry.
// Removal of any slot closes the gap, so valid slots stay contiguous.
module req_queue #(
  parameter int DEPTH = 8,
  parameter int CYL_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push_en,
  input  logic [CYL_W-1:0]            push_cyl,
  input  logic                        pop_en,
  input  logic [IDX_W-1:0]            pop_idx,
  output logic [DEPTH-1:0][CYL_W-1:0] slot_cyl,
  output logic [DEPTH-1:0]            slot_vld,
  output logic [CNT_W-1:0]            count
);

  logic [DEPTH-1:0][CYL_W-1:0] cyl_q, cyl_gap, cyl_nxt;
  logic [CNT_W-1:0]            cnt_q, cnt_gap, cnt_nxt;

  // close the gap left by a removal, then append behind the survivors
  always_comb begin
    cyl_gap = cyl_q;
    cnt_gap = cnt_q;
    if (pop_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) cyl_gap[i] = cyl_q[i+1];
      end
      cnt_gap = cnt_q - CNT_W'(1);
    end
    cyl_nxt = cyl_gap;
    cnt_nxt = cnt_gap;
    if (push_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_gap) cyl_nxt[i] = push_cyl;
      end
      cnt_nxt = cnt_gap + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
    cyl_q <= cyl_nxt;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign slot_vld[g] = (CNT_W'(g) < cnt_q);
    end
  endgenerate

  assign slot_cyl = cyl_q;
  assign count    = cnt_q;

endmodule

// File: rtl/seek_picker.sv
// Ranks every valid slot with one composite key and returns the minimum.
// Key = {outside current sweep, policy rank, cylinder}; a smaller key wins.
module seek_picker
  import disk_sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 199,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DIST_W = CYL_W + 2
) (
  input  logic [DEPTH-1:0][CYL_W-1:0] slot_cyl,
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [CYL_W-1:0]            head,
  input  logic                        dir_up,
  input  sched_pol_e                  pol,
  output logic [IDX_W-1:0]            pick_idx,
  output logic [CYL_W-1:0]            pick_cyl,
  output logic [DIST_W-1:0]           pick_dist,
  output logic                        pick_dir
);

  localparam int KEY_W = 1 + DIST_W + CYL_W;
  localparam logic [DIST_W-1:0] EDGE = DIST_W'(MAX_CYL);

  logic [DEPTH-1:0][KEY_W-1:0]  key;
  logic [DEPTH-1:0][DIST_W-1:0] cost;
  logic [DEPTH-1:0]             ndir;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [DIST_W-1:0] cx, hx, absd, c_cost, c_rank;
      logic              above, below, in_sweep, c_dir;

      always_comb begin
        cx       = DIST_W'(slot_cyl[g]);
        hx       = DIST_W'(head);
        above    = (cx >= hx);
        below    = (cx <= hx);
        absd     = above ? (cx - hx) : (hx - cx);
        in_sweep = 1'b1;
        c_cost   = absd;
        c_rank   = absd;
        c_dir    = (cx > hx) ? 1'b1 : ((cx < hx) ? 1'b0 : dir_up);
        case (pol)
          POL_NEAREST: ;
          POL_SWEEP: begin
            if (dir_up) begin
              in_sweep = above;
              c_dir    = above;
              if (!above) c_cost = (EDGE - hx) + (EDGE - cx);
            end else begin
              in_sweep = below;
              c_dir    = !below;
              if (!below) c_cost = hx + cx;
            end
            c_rank = c_cost;
          end
          POL_CSWEEP: begin
            in_sweep = above;
            c_dir    = 1'b1;
            if (!above) c_cost = (EDGE - hx) + EDGE + cx;
            c_rank   = c_cost;
          end
          POL_CLOOK: begin
            in_sweep = above;
            c_dir    = 1'b1;
            if (!above) begin
              c_cost = hx - cx;
              c_rank = cx;
            end
          end
          default: c_rank = DIST_W'(g);
        endcase
      end

      assign key[g]  = {~in_sweep, c_rank, slot_cyl[g]};
      assign cost[g] = c_cost;
      assign ndir[g] = c_dir;
    end
  endgenerate

  always_comb begin
    logic             found;
    logic [KEY_W-1:0] best;
    found    = 1'b0;
    best     = '0;
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_vld[i] && (!found || key[i] < best)) begin
        found    = 1'b1;
        best     = key[i];
        pick_idx = IDX_W'(i);
      end
    end
    pick_cyl  = slot_cyl[pick_idx];
    pick_dist = cost[pick_idx];
    pick_dir  = ndir[pick_idx];
  end

endmodule

// File: rtl/disk_arm_scheduler.sv
module disk_arm_scheduler
  import disk_sched_pkg::*;
#(
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 199,
  parameter int DEPTH   = 8,
  parameter int TOT_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYL_W-1:0] init_head,
  input  logic             init_dir_up,
  input  logic [2:0]       policy,
  input  logic             req_valid,
  input  logic [CYL_W-1:0] req_cyl,
  output logic             req_ready,
  output logic             gnt_valid,
  output logic [CYL_W-1:0] gnt_cyl,
  input  logic             gnt_ready,
  output logic [CYL_W-1:0] head_cyl,
  output logic             dir_up,
  output logic [TOT_W-1:0] total_move
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int DIST_W = CYL_W + 2;
  localparam logic [CYL_W-1:0] TOP_CYL = CYL_W'(MAX_CYL);

  logic [DEPTH-1:0][CYL_W-1:0] slot_cyl;
  logic [DEPTH-1:0]            slot_vld;
  logic [CNT_W-1:0]            q_count;

  logic [CYL_W-1:0]  head_q;
  logic              dir_q;
  logic [TOT_W-1:0]  tot_q;
  sched_pol_e        pol_q;

  logic              off_vld_q;
  logic [IDX_W-1:0]  off_idx_q;
  logic [CYL_W-1:0]  off_cyl_q;
  logic [DIST_W-1:0] off_dist_q;
  logic              off_dir_q;

  logic [IDX_W-1:0]  pick_idx;
  logic [CYL_W-1:0]  pick_cyl;
  logic [DIST_W-1:0] pick_dist;
  logic              pick_dir;

  logic              push_fire, pop_fire;
  logic [CYL_W-1:0]  req_clamped, init_clamped;

  assign req_clamped  = (req_cyl > TOP_CYL) ? TOP_CYL : req_cyl;
  assign init_clamped = (init_head > TOP_CYL) ? TOP_CYL : init_head;

  assign req_ready = (q_count != CNT_W'(DEPTH));
  assign push_fire = req_valid && req_ready;
  assign pop_fire  = off_vld_q && gnt_ready;

  req_queue #(
    .DEPTH (DEPTH),
    .CYL_W (CYL_W)
  ) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push_en  (push_fire),
    .push_cyl (req_clamped),
    .pop_en   (pop_fire),
    .pop_idx  (off_idx_q),
    .slot_cyl (slot_cyl),
    .slot_vld (slot_vld),
    .count    (q_count)
  );

  seek_picker #(
    .DEPTH   (DEPTH),
    .CYL_W   (CYL_W),
    .MAX_CYL (MAX_CYL)
  ) u_picker (
    .slot_cyl  (slot_cyl),
    .slot_vld  (slot_vld),
    .head      (head_q),
    .dir_up    (dir_q),
    .pol       (pol_q),
    .pick_idx  (pick_idx),
    .pick_cyl  (pick_cyl),
    .pick_dist (pick_dist),
    .pick_dir  (pick_dir)
  );

  // Arm state: head, direction, movement total and the sampled policy.
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= init_clamped;
      dir_q  <= init_dir_up;
      tot_q  <= '0;
      pol_q  <= pol_decode(policy);
    end else begin
      if (q_count == '0) pol_q <= pol_decode(policy);
      if (pop_fire) begin
        head_q <= off_cyl_q;
        dir_q  <= off_dir_q;
        tot_q  <= tot_q + TOT_W'(off_dist_q);
      end
    end
  end

  // Offer register: captured from a settled queue, then held until taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      off_vld_q <= 1'b0;
    end else if (pop_fire) begin
      off_vld_q <= 1'b0;
    end else if (!off_vld_q) begin
      off_vld_q <= (q_count != '0) && !push_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!off_vld_q) begin
      off_idx_q  <= pick_idx;
      off_cyl_q  <= pick_cyl;
      off_dist_q <= pick_dist;
      off_dir_q  <= pick_dir;
    end
  end

  assign gnt_valid  = off_vld_q;
  assign gnt_cyl    = off_cyl_q;
  assign head_cyl   = head_q;
  assign dir_up     = dir_q;
  assign total_move = tot_q;

endmodule

// File: rtl/disk_arm_scheduler_chk.sv
module disk_arm_scheduler_chk #(
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 199,
  parameter int CNT_W   = 4,
  parameter int TOT_W   = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             gnt_valid,
  input logic             gnt_ready,
  input logic [CYL_W-1:0] gnt_cyl,
  input logic [CYL_W-1:0] head_cyl,
  input logic             dir_up,
  input logic [TOT_W-1:0] total_move,
  input logic [CNT_W-1:0] q_count,
  input logic [2:0]       pol_code
);

  // R11: an offer that is not taken stays put
  a_r11_offer_held: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_cyl));

  // R1: grants stay inside the cylinder range
  a_r1_grant_in_range: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> gnt_cyl <= CYL_W'(MAX_CYL));

  // R1: head stays inside the cylinder range
  a_r1_head_in_range: assert property (@(posedge clk) disable iff (rst)
    head_cyl <= CYL_W'(MAX_CYL));

  // R7: accepted grant moves the head there
  a_r7_head_follows: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && gnt_ready |=> head_cyl == $past(gnt_cyl));

  // R7: nothing moves without an accepted grant
  a_r7_idle_still: assert property (@(posedge clk) disable iff (rst)
    !(gnt_valid && gnt_ready) |=> $stable(total_move) && $stable(head_cyl));

  // R8: empty queue never offers
  a_r8_empty_no_offer: assert property (@(posedge clk) disable iff (rst)
    q_count == '0 |-> !gnt_valid);

  // R6: circular policies keep the direction upward after a grant
  a_r6_circular_up: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && gnt_ready && (pol_code == 3'd3 || pol_code == 3'd4) |=> dir_up);

endmodule

bind disk_arm_scheduler disk_arm_scheduler_chk #(
  .CYL_W   (CYL_W),
  .MAX_CYL (MAX_CYL),
  .CNT_W   (CNT_W),
  .TOT_W   (TOT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .gnt_valid  (gnt_valid),
  .gnt_ready  (gnt_ready),
  .gnt_cyl    (gnt_cyl),
  .head_cyl   (head_cyl),
  .dir_up     (dir_up),
  .total_move (total_move),
  .q_count    (q_count),
  .pol_code   (pol_q)
);

// File: tb/tb_disk_arm_scheduler.sv
`timescale 1ns/1ps
module tb_disk_arm_scheduler;

  localparam int CYL_W = 8;
  localparam int TOT_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CYL_W-1:0] init_head = 8'd53;
  logic             init_dir_up = 1'b0;
  logic [2:0]       policy = 3'd0;
  logic             req_valid = 1'b0;
  logic [CYL_W-1:0] req_cyl = '0;
  logic             req_ready;
  logic             gnt_valid;
  logic [CYL_W-1:0] gnt_cyl;
  logic             gnt_ready = 1'b0;
  logic [CYL_W-1:0] head_cyl;
  logic             dir_up;
  logic [TOT_W-1:0] total_move;

  int n_checks = 0;
  int n_fails  = 0;

  int demo_list [8] = '{98, 183, 37, 122, 14, 124, 65, 67};

  always #2.5 clk = ~clk;

  disk_arm_scheduler #(.CYL_W(CYL_W), .TOT_W(TOT_W)) dut (
    .clk(clk), .rst(rst), .init_head(init_head), .init_dir_up(init_dir_up),
    .policy(policy), .req_valid(req_valid), .req_cyl(req_cyl),
    .req_ready(req_ready), .gnt_valid(gnt_valid), .gnt_cyl(gnt_cyl),
    .gnt_ready(gnt_ready), .head_cyl(head_cyl), .dir_up(dir_up),
    .total_move(total_move)
  );

  task automatic check_eq(input string rq, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input int h, input bit d, input int pol);
    rst = 1'b1;
    init_head = CYL_W'(h);
    init_dir_up = d;
    policy = 3'(pol);
    req_valid = 1'b0;
    gnt_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic push(input int c);
    req_valid = 1'b1;
    req_cyl = CYL_W'(c);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic pop_one(output int c);
    int guard = 0;
    while (!gnt_valid && guard < 50) begin
      @(posedge clk);
      #1 guard++;
    end
    c = gnt_cyl;
    gnt_ready = 1'b1;
    @(posedge clk);
    #1 gnt_ready = 1'b0;
  endtask

  task automatic run_demo(input int pol, input bit d, input int exp_o [8],
                          input int exp_tot, input string rq);
    int c;
    do_reset(53, d, pol);
    for (int i = 0; i < 8; i++) push(demo_list[i]);
    for (int i = 0; i < 8; i++) begin
      pop_one(c);
      check_eq(rq, $sformatf("grant %0d", i), c, exp_o[i]);
      check_eq("R7", "head after grant", int'(head_cyl), c);
    end
    check_eq(rq, "total movement", int'(total_move), exp_tot);
    repeat (2) @(posedge clk);
    #1 check_eq("R8", "no offer when empty", int'(gnt_valid), 0);
  endtask

  task automatic t_reset;
    do_reset(53, 0, 0);
    check_eq("R12", "gnt_valid at reset", int'(gnt_valid), 0);
    check_eq("R12", "req_ready at reset", int'(req_ready), 1);
    check_eq("R12", "head at reset", int'(head_cyl), 53);
    check_eq("R12", "dir at reset", int'(dir_up), 0);
    check_eq("R12", "total at reset", int'(total_move), 0);
    do_reset(230, 1, 0);
    check_eq("R1", "init head clamped", int'(head_cyl), 199);
    check_eq("R12", "dir up loaded", int'(dir_up), 1);
  endtask

  task automatic t_policies;
    run_demo(0, 0, '{98, 183, 37, 122, 14, 124, 65, 67}, 640, "R2");
    run_demo(1, 0, '{65, 67, 37, 14, 98, 122, 124, 183}, 236, "R3");
    run_demo(2, 0, '{37, 14, 65, 67, 98, 122, 124, 183}, 236, "R4");
    run_demo(2, 1, '{65, 67, 98, 122, 124, 183, 37, 14}, 331, "R4");
    run_demo(3, 0, '{65, 67, 98, 122, 124, 183, 14, 37}, 382, "R5");
    check_eq("R6", "circular dir up", int'(dir_up), 1);
    run_demo(4, 0, '{65, 67, 98, 122, 124, 183, 14, 37}, 322, "R6");
    check_eq("R6", "look dir up", int'(dir_up), 1);
  endtask

  task automatic t_unknown_code;
    int c;
    do_reset(100, 0, 7);
    push(10);
    push(120);
    pop_one(c);
    check_eq("R12", "code 7 arrival order first", c, 10);
    pop_one(c);
    check_eq("R12", "code 7 arrival order second", c, 120);
  endtask

  task automatic t_full;
    int c;
    do_reset(53, 0, 0);
    for (int i = 1; i <= 8; i++) push(i * 10);
    check_eq("R8", "ready low when full", int'(req_ready), 0);
    push(150);
    for (int i = 1; i <= 8; i++) begin
      pop_one(c);
      check_eq("R8", "full queue grant", c, i * 10);
    end
    repeat (3) @(posedge clk);
    #1 check_eq("R8", "dropped push never granted", int'(gnt_valid), 0);
    check_eq("R7", "total after full drain", int'(total_move), 113);
  endtask

  task automatic t_tie;
    int c;
    do_reset(100, 0, 1);
    push(105);
    push(95);
    pop_one(c);
    check_eq("R9", "tie picks lower", c, 95);
    pop_one(c);
    check_eq("R9", "tie second", c, 105);
  endtask

  task automatic t_policy_latch;
    int c;
    do_reset(53, 0, 0);
    push(98);
    push(183);
    push(37);
    policy = 3'd1;
    pop_one(c);
    check_eq("R10", "policy held first", c, 98);
    pop_one(c);
    check_eq("R10", "policy held second", c, 183);
    pop_one(c);
    check_eq("R10", "policy held third", c, 37);
    repeat (2) @(posedge clk);
    push(100);
    push(40);
    pop_one(c);
    check_eq("R10", "new policy after drain", c, 40);
    pop_one(c);
  endtask

  task automatic t_clamp;
    int c;
    do_reset(10, 0, 0);
    push(250);
    pop_one(c);
    check_eq("R1", "request clamped", c, 199);
    check_eq("R1", "head clamped", int'(head_cyl), 199);
  endtask

  task automatic t_hold;
    int c;
    do_reset(50, 0, 1);
    push(150);
    repeat (2) @(posedge clk);
    #1 check_eq("R11", "offer present", int'(gnt_valid), 1);
    push(51);
    repeat (3) @(posedge clk);
    #1 check_eq("R11", "offer unchanged", int'(gnt_cyl), 150);
    check_eq("R11", "offer still valid", int'(gnt_valid), 1);
    pop_one(c);
    check_eq("R11", "held grant taken", c, 150);
    pop_one(c);
    check_eq("R11", "late arrival next", c, 51);
    check_eq("R7", "total after hold", int'(total_move), 199);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R7 watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_policies();
    t_unknown_code();
    t_full();
    t_tie();
    t_policy_latch();
    t_clamp();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule